// File: doc/BRIEF.md
# Power Partition Gating Register Controller

This block keeps the power-enable state and the isolation clamp state for a parameterised number of power partitions. Each partition gets one power-enable output and one clamp output. Software reaches the block through a single-cycle register port made of an address, write data, a write strobe and a combinational read-data return.

Power is changed with a toggle command. One write names a partition index and flips that partition's power state. A read-only status word shows which partitions are powered. Clamps are released through a mask register. In that mask the bits of the video-decode and PCIe partitions are deliberately crossed over. The graphics partition is released only through its own register, and only by a write of zero. Turning a partition off re-arms its clamp, so every power-up needs a fresh release.

The default build has 25 partitions. Smaller counts such as 7, 14 and 23 are also supported.

Top module: `pwr_part_ctrl`

## Requirements
- R1: While rst_ni is low and after reset, every pwr_en_o bit is 0 (unpowered) and every clamp_o bit is 1 (clamped).
- R2: A write to byte offset 0x30 with bit 8 set flips pwr_en_o[k], where k is the value of write-data bits [7:0]. The change shows on the clock after the write edge, and a single write changes at most one partition.
- R3: A write to 0x30 with bit 8 clear, or with an index in bits [7:0] at or above NUM_PART, changes no output.
- R4: Reading offset 0x38 returns a word in which bit n equals pwr_en_o[n]. Bits at NUM_PART and above read 0. Writes to 0x38 change nothing.
- R5: A write to offset 0x34 releases the clamp (clamp_o goes to 0) of every powered partition whose mask bit is set. Mask bit n selects partition n, except for the partitions covered by R6 and R7.
- R6: Partitions 3 (PCIe) and 4 (video decode) have crossed mask bits. Mask bit 3 releases partition 4, and mask bit 4 releases partition 3.
- R7: Partition 1 (graphics) ignores mask bit 1. Its clamp is released only by a write of the value 0 to offset 0x2D4. A non-zero write there has no effect.
- R8: A clamp release aimed at an unpowered partition has no effect. Powering a partition off sets its clamp in the same cycle as pwr_en_o falls. An unpowered partition is therefore always clamped, and a later power-up stays clamped until a new release.
- R9: Reads of any offset other than 0x38, including the write-only offsets 0x30, 0x34 and 0x2D4, return 0. Writes to unmapped offsets change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (12) | Byte address of the register access |
| wdata_i | input | DATA_W (32) | Write data |
| we_i | input | 1 | Write strobe, one write per asserted cycle |
| rdata_o | output | DATA_W (32) | Combinational read data for addr_i |
| pwr_en_o | output | NUM_PART (25) | Power enable per partition, 1 = powered |
| clamp_o | output | NUM_PART (25) | Isolation clamp per partition, 1 = clamped |

## Verification
Every write changes pwr_en_o and clamp_o on the first clock edge after the strobe is sampled. rdata_o follows addr_i within the same cycle, and for the status offset it reflects the state after that edge. The bench updates its reference model at each rising edge with the inputs it drove half a cycle earlier. It compares the power, clamp and read outputs at every falling edge, so each result is sampled exactly one register stage after its stimulus. Directed reads placed after each scenario check the swapped mask bits, the graphics zero-write rule, the re-arm on power-off and the ignored writes against constants derived from the requirements.

// File: rtl/pwr_part_pkg.sv
package pwr_part_pkg;

  localparam int unsigned DEF_ADDR_W     = 12;
  localparam int unsigned DEF_DATA_W     = 32;
  localparam int unsigned DEF_NUM_PART   = 25;
  localparam int unsigned DEF_TOGGLE_OFS = 'h030;
  localparam int unsigned DEF_MASK_OFS   = 'h034;
  localparam int unsigned DEF_STATUS_OFS = 'h038;
  localparam int unsigned DEF_GFX_OFS    = 'h2D4;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_TOGGLE,
    ACC_MASK,
    ACC_GFX,
    ACC_STATUS
  } acc_e;

endpackage

// File: rtl/pwr_part_decode.sv
module pwr_part_decode
  import pwr_part_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned TOGGLE_OFS = DEF_TOGGLE_OFS,
  parameter int unsigned MASK_OFS   = DEF_MASK_OFS,
  parameter int unsigned STATUS_OFS = DEF_STATUS_OFS,
  parameter int unsigned GFX_OFS    = DEF_GFX_OFS
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output acc_e              kind_o,
  output logic              tog_we_o,
  output logic              mask_we_o,
  output logic              gfx_we_o
);

  always_comb begin
    if (addr_i == ADDR_W'(TOGGLE_OFS))      kind_o = ACC_TOGGLE;
    else if (addr_i == ADDR_W'(MASK_OFS))   kind_o = ACC_MASK;
    else if (addr_i == ADDR_W'(STATUS_OFS)) kind_o = ACC_STATUS;
    else if (addr_i == ADDR_W'(GFX_OFS))    kind_o = ACC_GFX;
    else                                    kind_o = ACC_NONE;
  end

  assign tog_we_o  = we_i && (kind_o == ACC_TOGGLE);
  assign mask_we_o = we_i && (kind_o == ACC_MASK);
  assign gfx_we_o  = we_i && (kind_o == ACC_GFX);

endmodule

// File: rtl/pwr_part_toggle.sv
module pwr_part_toggle #(
  parameter int unsigned NUM_PART = 25,
  parameter int unsigned IDX_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tog_we_i,
  input  logic                start_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [NUM_PART-1:0] pwr_o,
  output logic [NUM_PART-1:0] off_o
);

  logic [NUM_PART-1:0] sel;

  for (genvar g = 0; g < NUM_PART; g++) begin : g_part
    assign sel[g] = tog_we_i && start_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pwr_o[g] <= 1'b0;
      else if (sel[g]) pwr_o[g] <= ~pwr_o[g];
    end
  end

  // partitions being switched off at this edge
  assign off_o = sel & pwr_o;

endmodule

// File: rtl/pwr_part_clamp.sv
module pwr_part_clamp #(
  parameter int unsigned NUM_PART = 25,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SWAP_A   = 3,
  parameter int unsigned SWAP_B   = 4,
  parameter int unsigned GFX_IDX  = 1,
  parameter bit          GFX_OWN  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mask_we_i,
  input  logic                gfx_we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_PART-1:0] pwr_i,
  input  logic [NUM_PART-1:0] off_i,
  output logic [NUM_PART-1:0] clamp_o
);

  logic gfx_zero;
  assign gfx_zero = gfx_we_i && (wdata_i == '0);

  for (genvar g = 0; g < NUM_PART; g++) begin : g_part
    localparam int unsigned SRC = (g == SWAP_A) ? SWAP_B :
                                  (g == SWAP_B) ? SWAP_A : g;
    logic rel;

    if (GFX_OWN && (g == GFX_IDX)) begin : g_gfx
      assign rel = gfx_zero;
    end else begin : g_mask
      assign rel = mask_we_i && wdata_i[SRC];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                clamp_o[g] <= 1'b1;
      else if (off_i[g])          clamp_o[g] <= 1'b1;
      else if (rel && pwr_i[g])   clamp_o[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_part_readmux.sv
module pwr_part_readmux
  import pwr_part_pkg::*;
#(
  parameter int unsigned NUM_PART = 25,
  parameter int unsigned DATA_W   = 32
) (
  input  acc_e                kind_i,
  input  logic [NUM_PART-1:0] pwr_i,
  output logic [DATA_W-1:0]   rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (kind_i == ACC_STATUS) begin
      for (int i = 0; i < NUM_PART; i++) rdata_o[i] = pwr_i[i];
    end
  end

endmodule

// File: rtl/pwr_part_ctrl.sv
module pwr_part_ctrl
  import pwr_part_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned NUM_PART   = DEF_NUM_PART,
  parameter int unsigned TOGGLE_OFS = DEF_TOGGLE_OFS,
  parameter int unsigned MASK_OFS   = DEF_MASK_OFS,
  parameter int unsigned STATUS_OFS = DEF_STATUS_OFS,
  parameter int unsigned GFX_OFS    = DEF_GFX_OFS,
  parameter int unsigned START_BIT  = 8,
  parameter int unsigned SWAP_A     = 3,
  parameter int unsigned SWAP_B     = 4,
  parameter int unsigned GFX_IDX    = 1,
  parameter bit          GFX_OWN    = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                we_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PART-1:0] pwr_en_o,
  output logic [NUM_PART-1:0] clamp_o
);

  localparam int unsigned IDX_W = START_BIT;

  acc_e                kind;
  logic                tog_we, mask_we, gfx_we;
  logic [NUM_PART-1:0] off_now;

  pwr_part_decode #(
    .ADDR_W(ADDR_W), .TOGGLE_OFS(TOGGLE_OFS), .MASK_OFS(MASK_OFS),
    .STATUS_OFS(STATUS_OFS), .GFX_OFS(GFX_OFS)
  ) i_decode (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .kind_o   (kind),
    .tog_we_o (tog_we),
    .mask_we_o(mask_we),
    .gfx_we_o (gfx_we)
  );

  pwr_part_toggle #(
    .NUM_PART(NUM_PART), .IDX_W(IDX_W)
  ) i_toggle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tog_we_i(tog_we),
    .start_i (wdata_i[START_BIT]),
    .idx_i   (wdata_i[IDX_W-1:0]),
    .pwr_o   (pwr_en_o),
    .off_o   (off_now)
  );

  pwr_part_clamp #(
    .NUM_PART(NUM_PART), .DATA_W(DATA_W), .SWAP_A(SWAP_A),
    .SWAP_B(SWAP_B), .GFX_IDX(GFX_IDX), .GFX_OWN(GFX_OWN)
  ) i_clamp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(mask_we),
    .gfx_we_i (gfx_we),
    .wdata_i  (wdata_i),
    .pwr_i    (pwr_en_o),
    .off_i    (off_now),
    .clamp_o  (clamp_o)
  );

  pwr_part_readmux #(
    .NUM_PART(NUM_PART), .DATA_W(DATA_W)
  ) i_readmux (
    .kind_i (kind),
    .pwr_i  (pwr_en_o),
    .rdata_o(rdata_o)
  );

endmodule

// File: rtl/pwr_part_ctrl_chk.sv
module pwr_part_ctrl_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_PART   = 25,
  parameter int unsigned TOGGLE_OFS = 'h030,
  parameter int unsigned MASK_OFS   = 'h034,
  parameter int unsigned STATUS_OFS = 'h038,
  parameter int unsigned GFX_OFS    = 'h2D4,
  parameter int unsigned START_BIT  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                we_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_PART-1:0] pwr_en_o,
  input logic [NUM_PART-1:0] clamp_o
);

  logic              past_ok;
  logic              unmapped;
  logic [DATA_W-1:0] pwr_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign unmapped = (addr_i != ADDR_W'(TOGGLE_OFS)) && (addr_i != ADDR_W'(MASK_OFS)) &&
                    (addr_i != ADDR_W'(STATUS_OFS)) && (addr_i != ADDR_W'(GFX_OFS));

  always_comb begin
    pwr_ext = '0;
    for (int i = 0; i < NUM_PART; i++) pwr_ext[i] = pwr_en_o[i];
  end

  assert_single_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ($countones(pwr_en_o ^ $past(pwr_en_o)) <= 1));

  assert_no_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(TOGGLE_OFS) && !wdata_i[START_BIT]) |=> $stable(pwr_en_o));

  assert_status_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(STATUS_OFS)) |-> (rdata_o == pwr_ext));

  assert_gfx_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(GFX_OFS) && wdata_i != '0) |=> $stable(clamp_o));

  assert_unpowered_clamped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pwr_en_o & ~clamp_o) == '0));

  assert_unmapped_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && unmapped) |=> ($stable(pwr_en_o) && $stable(clamp_o)));

  assert_unmapped_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> (rdata_o == '0));

endmodule

bind pwr_part_ctrl pwr_part_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PART(NUM_PART),
  .TOGGLE_OFS(TOGGLE_OFS), .MASK_OFS(MASK_OFS), .STATUS_OFS(STATUS_OFS),
  .GFX_OFS(GFX_OFS), .START_BIT(START_BIT)
) i_pwr_part_ctrl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .rdata_o(rdata_o), .pwr_en_o(pwr_en_o), .clamp_o(clamp_o)
);

// File: tb/test_pwr_part_ctrl.sv
`timescale 1ns/1ps
module test_pwr_part_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NUM  = 25;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int WDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = 12'h038;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [DW-1:0] rdata;
  logic [NUM-1:0] pwr_en, clamp;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  logic [NUM-1:0] m_pwr, m_clamp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_part_ctrl i_pwr_part_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .pwr_en_o(pwr_en), .clamp_o(clamp)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr   = '0;
      m_clamp = '1;
    end else if (we) begin
      if (addr == 12'h030) begin
        if (wdata[8] && wdata[7:0] < NUM) begin
          int k;
          k = wdata[7:0];
          if (m_pwr[k]) begin m_pwr[k] = 1'b0; m_clamp[k] = 1'b1; end
          else m_pwr[k] = 1'b1;
        end
      end else if (addr == 12'h034) begin
        for (int p = 0; p < NUM; p++) begin
          int b;
          b = (p == 3) ? 4 : (p == 4) ? 3 : p;
          if (p != 1 && wdata[b] && m_pwr[p]) m_clamp[p] = 1'b0;
        end
      end else if (addr == 12'h2D4) begin
        if (wdata == 0 && m_pwr[1]) m_clamp[1] = 1'b0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    logic [DW-1:0] exp_rd;
    exp_rd = (addr == 12'h038) ? DW'(m_pwr) : '0;
    n_chk++;
    if (pwr_en !== m_pwr || clamp !== m_clamp || rdata !== exp_rd) begin
      n_fail++;
      $display("FAIL %s cycle compare: pwr=%h/%h clamp=%h/%h rdata=%h/%h (actual/expected)",
               cur_req, pwr_en, m_pwr, clamp, m_clamp, rdata, exp_rd);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk); #1;
    we = 1'b0; wdata = '0; addr = 12'h038;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); #1;
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_status(input string req, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(12'h038, v);
    chk(v === exp, req, v, exp);
  endtask

  task automatic chk_clamp(input string req, input logic [NUM-1:0] exp);
    @(negedge clk); #1;
    chk(clamp === exp, req, DW'(clamp), DW'(exp));
  endtask

  initial begin : wdog
    for (int c = 0; c < WDOG; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", WDOG, WDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [DW-1:0] v;
    logic [NUM-1:0] c_ref, p_ref;

    // R1 reset
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk(pwr_en === '0, "R1", DW'(pwr_en), 0);
    chk(clamp === '1, "R1", DW'(clamp), DW'({NUM{1'b1}}));
    #1 rst_n = 1'b1;
    chk_status("R1", 0);
    chk_clamp("R1", '1);

    // R2 toggle
    cur_req = "R2";
    wr(12'h030, 32'h100);
    wr(12'h030, 32'h105);
    wr(12'h030, 32'h118);
    chk_status("R2", 32'h0100_0021);
    wr(12'h030, 32'h105);
    chk_status("R2", 32'h0100_0001);

    // R3 ignored toggles
    cur_req = "R3";
    wr(12'h030, 32'h005);
    wr(12'h030, 32'h119);
    wr(12'h030, 32'h1C8);
    chk_status("R3", 32'h0100_0001);

    // R4 read-only status
    cur_req = "R4";
    wr(12'h038, 32'hFFFF_FFFF);
    chk_status("R4", 32'h0100_0001);
    chk_clamp("R4", '1);

    // R5 mask release
    cur_req = "R5";
    wr(12'h034, 32'h0000_0001);
    chk_clamp("R5", 25'h1FF_FFFE);
    wr(12'h034, 32'h0100_0000);
    chk_clamp("R5", 25'h0FF_FFFE);

    // R8 release of unpowered partition ignored
    cur_req = "R8";
    wr(12'h034, 32'h0000_0400);
    chk_clamp("R8", 25'h0FF_FFFE);

    // R6 swapped bits
    cur_req = "R6";
    wr(12'h030, 32'h103);
    wr(12'h034, 32'h0000_0008);
    chk_clamp("R6", 25'h0FF_FFFE);
    wr(12'h034, 32'h0000_0010);
    chk_clamp("R6", 25'h0FF_FFF6);
    wr(12'h030, 32'h104);
    wr(12'h034, 32'h0000_0010);
    chk_clamp("R6", 25'h0FF_FFF6);
    wr(12'h034, 32'h0000_0008);
    chk_clamp("R6", 25'h0FF_FFE6);

    // R7 graphics release
    cur_req = "R7";
    wr(12'h030, 32'h101);
    wr(12'h034, 32'h0000_0002);
    chk_clamp("R7", 25'h0FF_FFE6);
    wr(12'h2D4, 32'h0000_0005);
    chk_clamp("R7", 25'h0FF_FFE6);
    wr(12'h2D4, 32'h0);
    chk_clamp("R7", 25'h0FF_FFE4);

    // R8 power-off re-arms clamp
    cur_req = "R8";
    wr(12'h030, 32'h101);
    chk_clamp("R8", 25'h0FF_FFE6);
    chk_status("R8", 32'h0100_0019);
    wr(12'h030, 32'h101);
    chk_clamp("R8", 25'h0FF_FFE6);
    wr(12'h2D4, 32'h0);
    chk_clamp("R8", 25'h0FF_FFE4);

    // R9 unmapped and write-only offsets
    cur_req = "R9";
    rd(12'h100, v);
    chk(v === 0, "R9", v, 0);
    rd(12'h030, v);
    chk(v === 0, "R9", v, 0);
    rd(12'h034, v);
    chk(v === 0, "R9", v, 0);
    rd(12'h2D4, v);
    chk(v === 0, "R9", v, 0);
    c_ref = clamp; p_ref = pwr_en;
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h031, 32'h0000_0100);
    @(negedge clk); #1;
    chk(clamp === c_ref, "R9", DW'(clamp), DW'(c_ref));
    chk(pwr_en === p_ref, "R9", DW'(pwr_en), DW'(p_ref));

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule